// File: doc/BRIEF.md
# Management Alert Frame Transmitter

This block sends one management frame, loaded by the host into a private byte buffer of up to 128 entries, over a transmit path it shares with the normal MAC traffic. The host fills the buffer through a data register that auto-increments, writes the frame length, and sets a start bit. The block waits until the MAC reports that no normal frame is in flight, then streams the buffer as a valid/ready byte stream with a last-byte marker. It records how the MAC finished the frame and raises a done flag, which can drive an interrupt line.

Completion is always flagged, whether or not the frame got through. The host reads the status register to find out what happened: late collision, carrier loss, or a retry error when the MAC transmit logic was reset while this frame was backing off or colliding. The host can resend a frame by setting start again, without reloading the buffer.

Register map (byte-wide, 3-bit address): 0 = CTRL (bit0 irq enable, bit1 done mask), 1 = LEN, 2 = STAT (bit0 start, bit1 late collision, bit2 no carrier, bit3 retry error, bit4 any error), 3 = IRQ (bit0 tx done, bit1 rx done, bit2 any), 4 = DATA (write only). Registers that are not written read 0.

Top module: `alert_tx_ctrl`

## Requirements
- R1: After launch the buffer bytes at index 0 to LEN-1 leave in ascending order on `tx_data_o`. Each byte is held with `tx_valid_o` high until `tx_ready_i` is seen at a clock edge. `tx_last_o` is 1 only with byte LEN-1. LEN may be 1 to 128.
- R2: `tx_valid_o` stays low while `mac_busy_i` is high. Streaming starts only after a cycle with `mac_busy_i` low.
- R3: A DATA write (address 4) stores the byte at the load pointer and advances the pointer. Launching a frame resets the pointer to 0.
- R4: IRQ bit0 (tx done) sets when a frame completes, with or without errors. A read of address 3 clears it. All registers read 0 after reset.
- R5: Writing 1 to STAT bit0 sets start. Start stays 1 until the frame completes, then clears. STAT bits 4:1 read 0 while start is 1.
- R6: At completion STAT bit1 takes `mac_late_col_i` and bit2 takes `mac_no_carrier_i`, both sampled with `mac_done_i`. Bit4 is the OR of bits 3:1.
- R7: `irq_o` is high when tx done is 1, CTRL bit0 is 1 and CTRL bit1 is 0. It stays high until address 3 is read.
- R8: IRQ bit1 reflects `rx_done_i`, and IRQ bit2 is the OR of bits 1:0.
- R9: During streaming or while waiting for the end, `mac_reset_i` with `mac_retrying_i` high ends the frame at once. Tx done sets and STAT bit3 sets, with bits 2:1 clear. `mac_reset_i` with `mac_retrying_i` low has no effect.
- R10: Setting start again without reloading resends the same bytes with the same LEN. Writing start while start is 1 is ignored.
- R11: DATA writes while start is 1 are ignored. Neither the buffer nor the load pointer changes.
- R12: A read of address 3 in the same cycle as a completion returns tx done as 0. The new done stays set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_re_i | input | 1 | Host register read strobe (read side effects) |
| host_addr_i | input | 3 | Register address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data for `host_addr_i` |
| rx_done_i | input | 1 | Receive-done flag from the receive side |
| irq_o | output | 1 | Transmit-done interrupt |
| mac_busy_i | input | 1 | Normal frame (including retries) in progress |
| tx_valid_o | output | 1 | Byte valid toward the MAC |
| tx_data_o | output | 8 | Byte toward the MAC |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | MAC accepts the byte |
| mac_done_i | input | 1 | MAC finished the alert frame |
| mac_late_col_i | input | 1 | Late collision, valid with `mac_done_i` |
| mac_no_carrier_i | input | 1 | Loss of carrier, valid with `mac_done_i` |
| mac_reset_i | input | 1 | MAC transmit logic reset by a start/stop command |
| mac_retrying_i | input | 1 | Alert frame currently in backoff or collision |

## Verification
The bench targets the moment the interrupt register is read in the same cycle a frame completes. A design that gives the clear priority would lose that completion, and the next read would return 0. It writes DATA in mid-send and then reloads two bytes after a resend. A design that lets busy writes through, or that does not rewind the pointer at launch, would then stream the wrong bytes. It also sends a full 128-byte frame and a 1-byte frame under a stuttering ready. Off-by-one end detection would drop or add a byte, or misplace the last marker. It pulses a MAC reset both with and without the retrying flag. A design that ignores the qualifier would abort a healthy frame or miss the retry error.

// File: rtl/alert_tx_pkg.sv
package alert_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND, ST_END} seq_state_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_LEN  = 3'd1;
  localparam logic [2:0] REG_STAT = 3'd2;
  localparam logic [2:0] REG_IRQ  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;

  typedef struct packed {
    logic retry;
    logic no_carrier;
    logic late_col;
  } tx_err_t;
endpackage

// File: rtl/alert_tx_buf.sv
module alert_tx_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ptr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wr_ptr_q <= '0;
    else if (clr_ptr_i) wr_ptr_q <= '0;
    else if (we_i)      wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i && !clr_ptr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/alert_tx_seq.sv
module alert_tx_seq
  import alert_tx_pkg::*;
#(
  parameter int AW = 7,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [LW-1:0] len_i,
  input  logic          mac_busy_i,
  input  logic          tx_ready_i,
  input  logic          mac_done_i,
  input  logic          mac_late_col_i,
  input  logic          mac_no_carrier_i,
  input  logic          mac_reset_i,
  input  logic          mac_retrying_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  output logic          done_o,
  output tx_err_t       err_o
);
  localparam int PADW = LW + 1 - AW;

  seq_state_e    st_q, st_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [LW:0]   idx_inc;
  logic          active, abort, accept;

  assign idx_inc = {{PADW{1'b0}}, idx_q} + 1'b1;
  // len 0 sends one byte; len above DEPTH never terminates (undefined)
  assign tx_last_o  = (st_q == ST_SEND) && (idx_inc >= {1'b0, len_i});
  assign tx_valid_o = (st_q == ST_SEND);
  assign rd_addr_o  = idx_q;
  assign accept     = tx_valid_o && tx_ready_i;

  assign active = (st_q == ST_SEND) || (st_q == ST_END);
  assign abort  = active && mac_reset_i && mac_retrying_i;
  assign done_o = abort || ((st_q == ST_END) && mac_done_i);

  assign err_o.retry      = abort;
  assign err_o.late_col   = !abort && mac_late_col_i;
  assign err_o.no_carrier = !abort && mac_no_carrier_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (launch_i) st_d = ST_WAIT;
      ST_WAIT: if (!mac_busy_i) begin
        st_d  = ST_SEND;
        idx_d = '0;
      end
      ST_SEND: if (accept) begin
        if (tx_last_o) st_d = ST_END;
        else           idx_d = idx_q + 1'b1;
      end
      ST_END:  ;
      default: st_d = ST_IDLE;
    endcase
    if (done_o) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/alert_tx_regs.sv
module alert_tx_regs
  import alert_tx_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic          host_re_i,
  input  logic [2:0]    host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          rx_done_i,
  input  logic          done_i,
  input  tx_err_t       err_i,
  output logic          start_o,
  output logic          launch_o,
  output logic          data_we_o,
  output logic [LW-1:0] len_o,
  output logic          tx_done_o,
  output logic          irq_o
);
  logic    irq_en_q, done_mask_q, start_q, tx_done_q;
  logic    [LW-1:0] len_q;
  tx_err_t err_q;
  logic    irq_rd, any_err;

  assign launch_o  = host_we_i && (host_addr_i == REG_STAT) && host_wdata_i[0] && !start_q;
  assign data_we_o = host_we_i && (host_addr_i == REG_DATA) && !start_q;
  assign irq_rd    = host_re_i && (host_addr_i == REG_IRQ);
  assign any_err   = |err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q    <= 1'b0;
      done_mask_q <= 1'b0;
      len_q       <= '0;
      start_q     <= 1'b0;
      err_q       <= '0;
      tx_done_q   <= 1'b0;
    end else begin
      if (host_we_i && host_addr_i == REG_CTRL) begin
        irq_en_q    <= host_wdata_i[0];
        done_mask_q <= host_wdata_i[1];
      end
      if (host_we_i && host_addr_i == REG_LEN) len_q <= host_wdata_i[LW-1:0];
      if (launch_o) begin
        start_q <= 1'b1;
        err_q   <= '0;
      end else if (done_i) begin
        start_q <= 1'b0;
        err_q   <= err_i;
      end
      // a completion wins over the clearing read
      tx_done_q <= done_i || (tx_done_q && !irq_rd);
    end
  end

  always_comb begin
    host_rdata_o = '0;
    unique case (host_addr_i)
      REG_CTRL: host_rdata_o[1:0] = {done_mask_q, irq_en_q};
      REG_LEN:  host_rdata_o[LW-1:0] = len_q;
      REG_STAT: if (!start_q) host_rdata_o[4:1] = {any_err, err_q.retry, err_q.no_carrier, err_q.late_col};
                else          host_rdata_o[0]   = 1'b1;
      REG_IRQ:  host_rdata_o[2:0] = {tx_done_q || rx_done_i, rx_done_i, tx_done_q};
      default:  host_rdata_o = '0;
    endcase
  end

  assign start_o   = start_q;
  assign len_o     = len_q;
  assign tx_done_o = tx_done_q;
  assign irq_o     = tx_done_q && irq_en_q && !done_mask_q;
endmodule

// File: rtl/alert_tx_ctrl.sv
module alert_tx_ctrl
  import alert_tx_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_we_i,
  input  logic       host_re_i,
  input  logic [2:0] host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  input  logic       rx_done_i,
  output logic       irq_o,
  input  logic       mac_busy_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       tx_last_o,
  input  logic       tx_ready_i,
  input  logic       mac_done_i,
  input  logic       mac_late_col_i,
  input  logic       mac_no_carrier_i,
  input  logic       mac_reset_i,
  input  logic       mac_retrying_i
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic          start_w, launch_w, data_we_w, done_w, tx_done_w;
  logic [LW-1:0] len_w;
  logic [AW-1:0] rd_addr_w;
  tx_err_t       err_w;

  alert_tx_regs #(.LW(LW)) i_regs (
    .clk_i, .rst_ni, .host_we_i, .host_re_i, .host_addr_i, .host_wdata_i,
    .host_rdata_o, .rx_done_i,
    .done_i(done_w), .err_i(err_w), .start_o(start_w), .launch_o(launch_w),
    .data_we_o(data_we_w), .len_o(len_w), .tx_done_o(tx_done_w), .irq_o
  );

  alert_tx_buf #(.DEPTH(DEPTH), .DW(8)) i_buf (
    .clk_i, .rst_ni, .clr_ptr_i(launch_w), .we_i(data_we_w),
    .wdata_i(host_wdata_i), .rd_addr_i(rd_addr_w), .rd_data_o(tx_data_o)
  );

  alert_tx_seq #(.AW(AW), .LW(LW)) i_seq (
    .clk_i, .rst_ni, .launch_i(launch_w), .len_i(len_w), .mac_busy_i, .tx_ready_i,
    .mac_done_i, .mac_late_col_i, .mac_no_carrier_i, .mac_reset_i, .mac_retrying_i,
    .rd_addr_o(rd_addr_w), .tx_valid_o, .tx_last_o, .done_o(done_w), .err_o(err_w)
  );
endmodule

// File: rtl/alert_tx_chk.sv
module alert_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_we_i,
  input logic       host_re_i,
  input logic [2:0] host_addr_i,
  input logic       mac_busy_i,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       irq_o,
  input logic       mac_reset_i,
  input logic       mac_retrying_i,
  input logic       done_w,
  input logic       start_w,
  input logic       tx_done_w
);
  logic irq_rd, abort_in;
  assign irq_rd   = host_re_i && (host_addr_i == 3'd3);
  assign abort_in = mac_reset_i && mac_retrying_i;

  AST_LAUNCH_WAITS_MAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(!mac_busy_i)); // R2
  AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !abort_in |=> tx_valid_o && $stable(tx_data_o)); // R1
  AST_DONE_CLEARS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> !start_w); // R5
  AST_START_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w && !done_w |=> start_w); // R5
  AST_DONE_NOT_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> tx_done_w); // R12
  AST_READ_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_w && irq_rd && !done_w |=> !tx_done_w); // R4
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_rd && !host_we_i && !done_w |=> irq_o); // R7
endmodule

bind alert_tx_ctrl alert_tx_chk i_chk (
  .clk_i, .rst_ni, .host_we_i, .host_re_i, .host_addr_i, .mac_busy_i,
  .tx_valid_o, .tx_ready_i, .tx_data_o, .irq_o, .mac_reset_i, .mac_retrying_i,
  .done_w, .start_w, .tx_done_w
);

// File: tb/test_alert_tx_ctrl.sv
module test_alert_tx_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       host_we_i = 0, host_re_i = 0;
  logic [2:0] host_addr_i = 0;
  logic [7:0] host_wdata_i = 0, host_rdata_o;
  logic       rx_done_i = 0, irq_o;
  logic       mac_busy_i = 0, tx_valid_o, tx_last_o, tx_ready_i = 1;
  logic [7:0] tx_data_o;
  logic       mac_done_i = 0, mac_late_col_i = 0, mac_no_carrier_i = 0;
  logic       mac_reset_i = 0, mac_retrying_i = 0;

  alert_tx_ctrl i_alert_tx_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int         n_chk = 0, n_err = 0;
  logic [8:0] exp_q [$];
  logic [8:0] exp_item;
  logic [7:0] model [128];
  string      cur_tag = "R1";
  bit         ready_stutter = 0;
  int         rdy_cnt = 0;
  logic [7:0] rv;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // ready pattern toward the design
  always @(negedge clk_i) begin
    rdy_cnt++;
    tx_ready_i = ready_stutter ? (rdy_cnt % 3 != 0) : 1'b1;
  end

  // monitor: pop and compare every accepted byte
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL %s unexpected byte got %0h expected none", cur_tag, tx_data_o);
      end else begin
        exp_item = exp_q.pop_front();
        check({cur_tag, " byte/last"}, {23'd0, tx_last_o, tx_data_o}, {23'd0, exp_item});
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    @(posedge clk_i); #1 host_we_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk_i);
    host_re_i = 1; host_addr_i = a;
    #1 v = host_rdata_o;
    @(posedge clk_i); #1 host_re_i = 0;
  endtask

  task automatic push_frame(int len);
    for (int i = 0; i < len; i++) exp_q.push_back({(i == len - 1), model[i]});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  task automatic mac_finish(logic late, logic nocar);
    @(negedge clk_i);
    mac_done_i = 1; mac_late_col_i = late; mac_no_carrier_i = nocar;
    @(posedge clk_i); #1 mac_done_i = 0; mac_late_col_i = 0; mac_no_carrier_i = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog got hang expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // reset state (R4)
    rd(3'd0, rv); check("R4 reset CTRL", rv, 0);
    rd(3'd1, rv); check("R4 reset LEN", rv, 0);
    rd(3'd2, rv); check("R4 reset STAT", rv, 0);
    rd(3'd3, rv); check("R4 reset IRQ", rv, 0);
    check("R4 reset irq_o", irq_o, 0);
    check("R4 reset tx_valid", tx_valid_o, 0);

    // frame 1: wait behind busy MAC, clean completion
    wr(3'd0, 8'h01);
    wr(3'd1, 8'd5);
    for (int i = 0; i < 5; i++) begin model[i] = 8'h10 + 8'(i); wr(3'd4, model[i]); end
    mac_busy_i = 1;
    cur_tag = "R1";
    wr(3'd2, 8'h01);
    push_frame(5);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); #2 check("R2 held while busy", tx_valid_o, 0);
    end
    rd(3'd2, rv); check("R5 start set, errors hidden", rv, 8'h01);
    @(negedge clk_i) mac_busy_i = 0;
    drain();
    rd(3'd2, rv); check("R5 start held until done", rv, 8'h01);
    mac_finish(0, 0);
    @(negedge clk_i); #2 check("R7 irq on done", irq_o, 1);
    rd(3'd2, rv); check("R5 start cleared", rv, 8'h00);
    rd(3'd3, rv); check("R4 tx done set", rv, 8'h05);
    @(negedge clk_i); #2 check("R7 irq cleared by read", irq_o, 0);
    rd(3'd3, rv); check("R4 tx done cleared", rv, 8'h00);

    // frame 2: resend without reload; busy writes ignored; non-retry reset ignored
    cur_tag = "R10";
    ready_stutter = 1;
    wr(3'd2, 8'h01);
    push_frame(5);
    wr(3'd4, 8'hEE);            // R11 ignored
    wr(3'd2, 8'h01);            // R10 second start ignored
    @(negedge clk_i); mac_reset_i = 1; mac_retrying_i = 0;
    @(posedge clk_i); #1 mac_reset_i = 0;
    drain();
    rd(3'd2, rv); check("R9 reset w/o retrying ignored", rv, 8'h01);
    mac_finish(1, 1);
    rd(3'd2, rv); check("R6 late+nocarrier status", rv, 8'h16);
    rd(3'd3, rv); check("R4 done despite errors", rv, 8'h05);

    // frame 3: pointer rewound at launch, only two bytes replaced
    cur_tag = "R3/R11";
    model[0] = 8'hAA; model[1] = 8'hBB;
    wr(3'd4, 8'hAA); wr(3'd4, 8'hBB);
    wr(3'd2, 8'h01);
    push_frame(5);
    drain();
    mac_finish(0, 1);
    rd(3'd2, rv); check("R6 no carrier status", rv, 8'h14);
    rd(3'd3, rv); check("R4 done frame 3", rv, 8'h05);

    // frame 4: retry error with interrupt masked
    cur_tag = "R9";
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h01);
    push_frame(5);
    drain();
    @(negedge clk_i); mac_reset_i = 1; mac_retrying_i = 1;
    @(posedge clk_i); #1 mac_reset_i = 0; mac_retrying_i = 0;
    rd(3'd2, rv); check("R9 retry error status", rv, 8'h18);
    @(negedge clk_i); #2 check("R7 masked irq stays low", irq_o, 0);
    rd(3'd3, rv); check("R9 abort flags done", rv, 8'h05);

    // frame 5: completion racing an IRQ read, interrupt disabled
    cur_tag = "R12";
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h01);
    push_frame(5);
    drain();
    @(negedge clk_i);
    mac_done_i = 1; host_re_i = 1; host_addr_i = 3'd3;
    #1 rv = host_rdata_o;
    @(posedge clk_i); #1 mac_done_i = 0; host_re_i = 0;
    check("R12 racing read sees old done", rv, 8'h00);
    @(negedge clk_i); #2 check("R7 disabled irq stays low", irq_o, 0);
    rd(3'd3, rv); check("R12 done survives race", rv, 8'h05);
    rd(3'd3, rv); check("R12 done cleared after", rv, 8'h00);

    // receive flag merge
    rx_done_i = 1;
    rd(3'd3, rv); check("R8 rx done and any", rv, 8'h06);
    rx_done_i = 0;

    // full 128-byte frame
    cur_tag = "R1 full";
    wr(3'd1, 8'd128);
    for (int i = 0; i < 128; i++) begin model[i] = 8'(i * 3 + 1); wr(3'd4, model[i]); end
    wr(3'd2, 8'h01);
    push_frame(128);
    drain();
    mac_finish(0, 0);
    rd(3'd2, rv); check("R6 clean status", rv, 8'h00);
    rd(3'd3, rv); check("R4 done full frame", rv, 8'h05);

    // single-byte frame
    cur_tag = "R1 one";
    wr(3'd1, 8'd1);
    wr(3'd2, 8'h01);
    push_frame(1);
    drain();
    mac_finish(0, 0);
    repeat (3) @(negedge clk_i);
    check("R1 no extra byte", exp_q.size(), 0);
    rd(3'd3, rv); check("R4 done one-byte frame", rv, 8'h05);

    summary();
  end
endmodule